// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a hardware watchdog with a single bus-visible control register. The first write to that register after reset configures it: a 12-bit reload value, a prescaler select, an enable and a 2-bit timeout-action code. From then on the configuration is frozen. Every further write to the same address is a keepalive kick, whatever its data. A kick reloads the down-counter and clears any pending timeout. Software that configures the block must therefore pick its period once, and then kick it often enough.

While running, the counter steps down once per tick. A tick is either every clock, or one clock in 16384 when the prescaler is selected. When a tick arrives with the count already at zero, the watchdog expires. It then raises an interrupt, a reset request or both, as the action code selects. These outputs stay high until a kick or a reset. A read port returns the frozen configuration with a lock flag, or the live count.

Control is a four-state machine:
- ST_CFG_WAIT is the state after reset. It leaves on the configuring write: to ST_COUNTING when the enable bit is set, and to ST_HALTED when it is clear.
- ST_HALTED is terminal until reset.
- ST_COUNTING moves to ST_EXPIRED on a tick taken at count zero with no kick in the same cycle.
- ST_EXPIRED returns to ST_COUNTING on a kick.

Top module: `wdog_once`

## Requirements
- R1: After reset both outputs are low, the lock flag reads 0, the configuration reads 0 and the count reads 0.
- R2: The first write to address 0x00 stores data bits 11:0 (reload), bit 12 (prescaler select), bit 13 (enable) and bits 15:14 (action), and sets the lock flag. No later write changes these fields. Writes to any other address are ignored.
- R3: On an enabling configuration write, the count loads the reload value. With bit 12 clear, it then decrements every clock. Timeout outputs rise exactly reload+1 clocks after the write edge, so a reload of 0 expires on the next edge.
- R4: With bit 12 set, the count decrements once every 16384 clocks. Timeout occurs (reload+1)*16384 clocks after the loading edge.
- R5: Any write to address 0x00 once locked, whatever its data, reloads the count from the stored reload value, restarts the prescaler, and drops both outputs on the next edge. A kick before expiry postpones the timeout by a full period.
- R6: The action code selects the outputs: 2 raises the interrupt only, 3 raises the interrupt and the reset request, and 0 or 1 raise the reset request only.
- R7: After expiry the outputs stay high and the count holds at 0 until a kick or reset.
- R8: If enable was clear in the configuring write, the counter never loads or runs, the block never times out, and later kicks cannot start it.
- R9: Reading address 0x00 returns the stored configuration in bits 15:0 and the lock flag in bit 16. Reading address 0x04 returns the count in bits 11:0. Any other read address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read address, combinational read |
| rd_data | output | 32 | Read data |
| wdt_irq | output | 1 | Timeout interrupt, held until kick or reset |
| sys_rst_req | output | 1 | Timeout reset request, held until kick or reset |

## Verification
The scoreboard records the exact clock of every rising timeout and the expected values of both outputs.

It checks several cases:
- A reload of zero, where an off-by-one count would expire a cycle late.
- A kick whose data carries a different reload, prescaler and action. A design that re-latches on later writes would expire at a different time, or assert the reset request.
- A second kick before expiry, which must push the timeout a full period out; a prescaler that is not cleared would expire early.
- A disabled configuration followed by an enabling write, which a lock that is too weak would let start.
- The prescaled path, measured to the exact clock.
- All four action codes.

// File: rtl/wdog_once_pkg.sv
package wdog_once_pkg;

    typedef enum logic [1:0] {
        ST_CFG_WAIT = 2'd0,
        ST_HALTED   = 2'd1,
        ST_COUNTING = 2'd2,
        ST_EXPIRED  = 2'd3
    } wd_state_e;

    // returns {interrupt, reset request} for a timeout action code
    function automatic logic [1:0] action_outputs(input logic [1:0] act);
        logic [1:0] res;
        unique case (act)
            2'd2:    res = 2'b10;
            2'd3:    res = 2'b11;
            default: res = 2'b01;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/wdog_cfg_lock.sv
module wdog_cfg_lock #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int RLD_W  = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                locked,
    output logic [RLD_W+3:0]    cfg,
    output logic [RLD_W+3:0]    cfg_next,
    output logic                cfg_load,
    output logic                kick
);
    localparam int CFG_W = RLD_W + 4;

    logic hit;
    wire  unused_hi = ^wr_data[DATA_W-1:CFG_W];

    assign hit      = wr_en && (wr_addr == REG_ADDR);
    assign cfg_load = hit && !locked;
    assign kick     = hit && locked;
    assign cfg_next = cfg_load ? wr_data[CFG_W-1:0] : cfg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            cfg    <= '0;
        end else if (cfg_load) begin
            locked <= 1'b1;
            cfg    <= wr_data[CFG_W-1:0];
        end
    end

    // R2: once locked, configuration never moves and lock never drops
    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(cfg)));

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic bypass,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (!rst_n)            pre <= '0;
        else if (clr || !run)  pre <= '0;
        else if (pre == LAST)  pre <= '0;
        else                   pre <= pre + 1'b1;
    end

    assign tick = run && !clr && (bypass || (pre == LAST));

    // R4: prescaled ticks are never back to back
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (DIV > 1 && !bypass && tick) |=> !tick);

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_once_pkg::*;
#(
    parameter int RLD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              kick,
    input  logic [RLD_W-1:0]  reload,
    input  logic              enable,
    input  logic [1:0]        action,
    input  logic              tick,
    output wd_state_e         state,
    output logic [RLD_W-1:0]  count,
    output logic              irq,
    output logic              rst_req
);
    wd_state_e state_nx;
    logic      expire;
    logic      load_cnt;

    assign expire   = (state == ST_COUNTING) && tick && !kick && (count == '0);
    assign load_cnt = (cfg_load && enable) || (kick && state != ST_HALTED);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CFG_WAIT: if (cfg_load) state_nx = enable ? ST_COUNTING : ST_HALTED;
            ST_HALTED:   state_nx = ST_HALTED;
            ST_COUNTING: if (expire) state_nx = ST_EXPIRED;
            ST_EXPIRED:  if (kick) state_nx = ST_COUNTING;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CFG_WAIT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_cnt)
            count <= reload;
        else if (state == ST_COUNTING && tick && count != '0)
            count <= count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else if (kick) begin
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else if (expire) begin
            {irq, rst_req} <= action_outputs(action);
        end
    end

    // R7: outputs hold until a kick
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !kick) |=> irq);
    // R5: a kick on a live watchdog reloads the count
    p_kick_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && state != ST_HALTED) |=> (count == $past(reload)));
    // R6: action code 2 never requests a reset
    p_irq_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> (action != 2'd2));
    // R8: a halted watchdog stays silent
    p_halted_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED) |-> (!irq && !rst_req && count == '0));
    // R3: the count never exceeds the stored reload while running
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNTING) |-> (count <= reload));

endmodule

// File: rtl/wdog_once.sv
module wdog_once
    import wdog_once_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int RLD_W   = 12,
    parameter int PRE_DIV = 16384,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h00,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdt_irq,
    output logic              sys_rst_req
);
    localparam int CFG_W   = RLD_W + 4;
    localparam int PRE_BIT = RLD_W;
    localparam int EN_BIT  = RLD_W + 1;
    localparam int ACT_LO  = RLD_W + 2;

    logic             locked, cfg_load, kick, tick;
    logic [CFG_W-1:0] cfg, cfg_next;
    logic [RLD_W-1:0] count;
    wd_state_e        state;

    wdog_cfg_lock #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RLD_W(RLD_W), .REG_ADDR(CFG_ADDR)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .locked(locked), .cfg(cfg), .cfg_next(cfg_next),
        .cfg_load(cfg_load), .kick(kick)
    );

    wdog_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(state == ST_COUNTING),
        .clr(kick || cfg_load), .bypass(!cfg_next[PRE_BIT]), .tick(tick)
    );

    wdog_fsm #(.RLD_W(RLD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .kick(kick),
        .reload(cfg_next[RLD_W-1:0]), .enable(cfg_next[EN_BIT]),
        .action(cfg_next[ACT_LO+1:ACT_LO]), .tick(tick), .state(state),
        .count(count), .irq(wdt_irq), .rst_req(sys_rst_req)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == CFG_ADDR)      rd_data[CFG_W:0]   = {locked, cfg};
        else if (rd_addr == CNT_ADDR) rd_data[RLD_W-1:0] = count;
    end

endmodule

// File: tb/sim_wdog_once.sv
module sim_wdog_once;
    localparam int PRE = 16384;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [7:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    wire  [31:0] rd_data;
    wire         wdt_irq, sys_rst_req;

    always #4 clk = ~clk;   // 125 MHz

    wdog_once u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wdt_irq(wdt_irq), .sys_rst_req(sys_rst_req)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int at; bit irq; bit rst; string tag; } exp_t;
    exp_t expq[$];
    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: compares each rising timeout against the scoreboard queue
    bit prev_any = 1'b0;
    always @(negedge clk) begin
        bit any_now;
        exp_t e;
        any_now = wdt_irq || sys_rst_req;
        if (rst_n && any_now && !prev_any) begin
            if (expq.size() == 0) begin
                check(1'b0, "R8", "unexpected timeout at cycle", cyc, 0);
            end else begin
                e = expq.pop_front();
                check(cyc == e.at, e.tag, "timeout cycle", cyc, e.at);
                check(wdt_irq == e.irq, e.tag, "interrupt", wdt_irq, e.irq);
                check(sys_rst_req == e.rst, e.tag, "reset request", sys_rst_req, e.rst);
            end
        end
        prev_any = rst_n ? any_now : 1'b0;
    end

    function automatic logic [31:0] mk(input int rld, input bit pre, input bit en,
                                       input logic [1:0] act);
        return {16'h0, act, en, pre, rld[11:0]};
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output int edge_cyc);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        edge_cyc = cyc;
    endtask

    task automatic expect_to(input int at, input bit i, input bit r, input string tag);
        exp_t e;
        e.at = at; e.irq = i; e.rst = r; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [31:0] exp,
                            input string req, input string what);
        rd_addr = a;
        #1;
        check(rd_data == exp, req, what, rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual %0d expected done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : driver
        int e, k, k2;
        do_reset();
        // R1 reset state, R9 read map
        check(!wdt_irq && !sys_rst_req, "R1", "outputs after reset",
              {wdt_irq, sys_rst_req}, 0);
        read_chk(8'h00, 32'h0, "R1", "config after reset");
        read_chk(8'h04, 32'h0, "R1", "count after reset");

        // R2 write to another address is ignored
        bus_write(8'h08, mk(5, 0, 1, 2), e);
        repeat (20) @(negedge clk);
        read_chk(8'h00, 32'h0, "R2", "stray write leaves unlocked");

        // R3 configure, irq-only action
        bus_write(8'h00, mk(5, 0, 1, 2), e);
        expect_to(e + 6, 1, 0, "R3");
        read_chk(8'h04, 32'd5, "R3", "count loaded");
        wait_until(e + 2);
        read_chk(8'h04, 32'd3, "R9", "count mid run");
        read_chk(8'h00, 32'h1_0000 | mk(5, 0, 1, 2), "R9", "locked config readback");
        read_chk(8'h10, 32'h0, "R9", "unmapped read");
        wait_until(e + 12);
        check(wdt_irq == 1'b1, "R7", "interrupt held", wdt_irq, 1);
        read_chk(8'h04, 32'd0, "R7", "count held at zero");

        // R5 kick with different data clears and reloads; R2 config unchanged
        bus_write(8'h00, mk(2, 1, 0, 3), k);
        check(!wdt_irq && !sys_rst_req, "R5", "outputs cleared by kick",
              {wdt_irq, sys_rst_req}, 0);
        read_chk(8'h04, 32'd5, "R5", "count reloaded by kick");
        read_chk(8'h00, 32'h1_0000 | mk(5, 0, 1, 2), "R2", "config survives kick");
        wait_until(k + 3);
        bus_write(8'h00, 32'hFFFF_FFFF, k2);
        expect_to(k2 + 6, 1, 0, "R5");
        wait_until(k2 + 10);
        check(expq.size() == 0, "R5", "pending after rekick", expq.size(), 0);

        // R6 both outputs
        do_reset();
        bus_write(8'h00, mk(3, 0, 1, 3), e);
        expect_to(e + 4, 1, 1, "R6");
        wait_until(e + 8);

        // R6 reset-only, R3 reload of zero
        do_reset();
        bus_write(8'h00, mk(0, 0, 1, 0), e);
        expect_to(e + 1, 0, 1, "R3");
        wait_until(e + 5);

        do_reset();
        bus_write(8'h00, mk(7, 0, 1, 1), e);
        expect_to(e + 8, 0, 1, "R6");
        wait_until(e + 12);

        // R8 disabled configuration cannot be started
        do_reset();
        bus_write(8'h00, mk(4, 0, 0, 2), e);
        repeat (50) @(negedge clk);
        bus_write(8'h00, mk(4, 0, 1, 2), k);
        repeat (50) @(negedge clk);
        read_chk(8'h04, 32'd0, "R8", "count never loaded");
        read_chk(8'h00, 32'h1_0000 | mk(4, 0, 0, 2), "R8", "enable stays clear");
        check(!wdt_irq && !sys_rst_req, "R8", "no timeout", {wdt_irq, sys_rst_req}, 0);

        // R4 prescaled period
        do_reset();
        bus_write(8'h00, mk(1, 1, 1, 2), e);
        expect_to(e + 2 * PRE, 1, 0, "R4");
        wait_until(e + PRE - 1);
        read_chk(8'h04, 32'd1, "R4", "count before first prescaled tick");
        wait_until(e + PRE);
        read_chk(8'h04, 32'd0, "R4", "count after first prescaled tick");
        wait_until(e + 2 * PRE + 4);

        check(expq.size() == 0, "R3", "missed timeouts", expq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule